// File: doc/BRIEF.md
# Occupancy-Tagged FIFO Stress Generator

This block drives a 32-bit test stream into an external dual-port FIFO so that a consumer can work out the FIFO's fill history and any word loss from the received data alone. Each word carries two 16-bit fields. The low field is a running sequence number, so a gap in the received sequence means words were lost. The high field is a live count of words taken out of the FIFO on its read side, which the block tracks by watching the read handshake. Comparing that count with the sequence number gives the occupancy of the FIFO at the moment each word was written.

The write side can run on every cycle or with a fixed duty pattern of three write slots followed by one idle slot. When the FIFO is full, the block either waits (stop-on-full) or deliberately throws the word away and counts the loss in a saturating overflow counter (drop mode). The FIFO's almost-empty and almost-full flags, which the FIFO sets at 30 % and 70 % of its depth (256 words by default), are registered and reported as coarse occupancy status. Everything runs on one clock with a synchronous active-high reset.

The write port follows valid/ready rules with one deliberate difference. `wr_valid` marks a write slot. A word counts as accepted on any cycle where both `wr_valid` and `wr_ready` are high. In stop-on-full mode, a slot that meets `wr_ready` low keeps `wr_valid` high and keeps the sequence field unchanged until the word is accepted. In drop mode, such a slot discards the word and the next slot presents the next sequence number. The drain field always shows the drain count of the current cycle, so it may change while a word is stalled.

Top module: `occ_tag_stress_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the sequence, drain and overflow counters clear, both occupancy status outputs clear, and the duty phase returns to its first write slot.
- R2: With `cfg_enable` low, `wr_valid` is 0. With `cfg_enable` high and `cfg_throttle` low, `wr_valid` is 1 on every cycle. With `cfg_throttle` high, `wr_valid` follows a 4-cycle pattern of 1,1,1,0 that starts at the first slot after reset, and the phase advances only on enabled cycles.
- R3: `wr_data[15:0]` is the sequence number and `wr_data[31:16]` is the drain count in the same cycle. Accepted words reach the FIFO read side in order and unchanged.
- R4: The sequence number goes up by one, modulo 2^16, after every slot that is either accepted or discarded. It holds in every other cycle.
- R5: With `cfg_stop_on_full` high, a slot with `wr_ready` low leaves the sequence number and the overflow counter unchanged, and `wr_valid` stays high.
- R6: With `cfg_stop_on_full` low, a slot with `wr_ready` low is discarded and adds one to `overflow_count`. The number of missing sequence values seen on the read side equals the number of discarded words.
- R7: `overflow_count` saturates at 65535.
- R8: The drain count goes up by one on each cycle with `rd_en` high and `rd_empty` low, and wraps modulo 2^16.
- R9: `occ_low` and `occ_high` equal `fifo_almost_empty` and `fifo_almost_full` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides of the FIFO |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Runs the generator |
| cfg_throttle | input | 1 | 1 selects the 3-of-4 duty pattern, 0 selects full rate |
| cfg_stop_on_full | input | 1 | 1 waits while the FIFO is full, 0 drops words while it is full |
| wr_valid | output | 1 | Write slot is active |
| wr_ready | input | 1 | FIFO can accept a word (not full) |
| wr_data | output | 32 | {drain count, sequence number} |
| rd_en | input | 1 | FIFO read request seen on the read side |
| rd_empty | input | 1 | FIFO empty flag |
| fifo_almost_empty | input | 1 | FIFO occupancy at or below 30 % |
| fifo_almost_full | input | 1 | FIFO occupancy at or above 70 % |
| occ_low | output | 1 | Registered almost-empty status |
| occ_high | output | 1 | Registered almost-full status |
| overflow_count | output | 16 | Saturating count of discarded words |

## Verification
On every cycle the assertions check that the sequence number steps on each issued word and holds through a stall, that a drop adds exactly one to the overflow count and that the count stays at its maximum, that each read handshake steps the drain count, and that no throttled run is longer than three slots. Only the bench's scenarios can show the end-to-end properties. These are that the read side receives the accepted words in order, that the gaps in the received sequence add up to the overflow count after a drop episode, that the drain field wraps after more than 65536 reads, that the overflow counter saturates after a very long full period, and that the duty pattern restarts at the first slot after a reset in the middle of a run.

// File: rtl/stress_pkg.sv
package stress_pkg;

  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_STALL = 2'd1,
    WR_PUSH  = 2'd2,
    WR_DROP  = 2'd3
  } wr_outcome_t;

endpackage

// File: rtl/stress_duty.sv
module stress_duty #(
  parameter int unsigned PERIOD   = 4,
  parameter int unsigned ON_SLOTS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic throttle,
  output logic slot
);
  localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] phase_q;

  generate
    if ((1 << PW) == PERIOD) begin : g_pow2
      always_ff @(posedge clk) begin
        if (rst)     phase_q <= '0;
        else if (en) phase_q <= phase_q + 1'b1;
      end
    end else begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst)     phase_q <= '0;
        else if (en) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
    end
  endgenerate

  assign slot = en & (~throttle | ({1'b0, phase_q} < (PW+1)'(ON_SLOTS)));

  // Run-length checker: consecutive throttled slots never exceed ON_SLOTS
  logic [PW:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !(en && throttle)) run_q <= '0;
    else if (slot) begin
      if (run_q != '1) run_q <= run_q + 1'b1;
    end else run_q <= '0;
  end

  a_r2_run_bounded: assert property (@(posedge clk) disable iff (rst)
    (en && throttle && slot) |-> (run_q < (PW+1)'(ON_SLOTS)));

endmodule

// File: rtl/stress_seq.sv
module stress_seq
  import stress_pkg::*;
#(
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned OVF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_outcome_t      outcome,
  output logic [SEQ_W-1:0] seq,
  output logic [OVF_W-1:0] ovf
);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  logic issued;
  assign issued = (outcome == WR_PUSH) || (outcome == WR_DROP);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq <= '0;
      ovf <= '0;
    end else begin
      if (issued) seq <= seq + 1'b1;
      if ((outcome == WR_DROP) && (ovf != OVF_MAX)) ovf <= ovf + 1'b1;
    end
  end

  a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (outcome == WR_STALL) |=> ($stable(seq) && $stable(ovf)));

  a_r6_drop_counts: assert property (@(posedge clk) disable iff (rst)
    (outcome == WR_DROP && ovf != OVF_MAX) |=> (ovf == $past(ovf) + 1'b1));

  a_r7_ovf_saturates: assert property (@(posedge clk) disable iff (rst)
    (ovf == OVF_MAX) |=> (ovf == OVF_MAX));

endmodule

// File: rtl/stress_drain.sv
module stress_drain #(
  parameter int unsigned DRAIN_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic               rd_empty,
  input  logic               almost_empty,
  input  logic               almost_full,
  output logic [DRAIN_W-1:0] drain,
  output logic               occ_low,
  output logic               occ_high
);
  logic taken;
  assign taken = rd_en & ~rd_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      drain    <= '0;
      occ_low  <= 1'b0;
      occ_high <= 1'b0;
    end else begin
      if (taken) drain <= drain + 1'b1;
      occ_low  <= almost_empty;
      occ_high <= almost_full;
    end
  end

  a_r8_drain_step: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_empty) |=> (drain == $past(drain) + 1'b1));

  a_r8_drain_idle: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !rd_empty) |=> $stable(drain));

endmodule

// File: rtl/occ_tag_stress_gen.sv
module occ_tag_stress_gen
  import stress_pkg::*;
#(
  parameter int unsigned SEQ_W       = 16,
  parameter int unsigned DRAIN_W     = 16,
  parameter int unsigned OVF_W       = 16,
  parameter int unsigned DUTY_PERIOD = 4,
  parameter int unsigned DUTY_ON     = 3,
  localparam int unsigned DATA_W     = SEQ_W + DRAIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_throttle,
  input  logic              cfg_stop_on_full,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_empty,
  input  logic              fifo_almost_empty,
  input  logic              fifo_almost_full,
  output logic              occ_low,
  output logic              occ_high,
  output logic [OVF_W-1:0]  overflow_count
);
  logic               slot;
  wr_outcome_t        outcome;
  logic [SEQ_W-1:0]   seq;
  logic [DRAIN_W-1:0] drain;

  stress_duty #(.PERIOD(DUTY_PERIOD), .ON_SLOTS(DUTY_ON)) u_duty (
    .clk(clk), .rst(rst), .en(cfg_enable), .throttle(cfg_throttle), .slot(slot)
  );

  always_comb begin
    if (!slot)                 outcome = WR_IDLE;
    else if (wr_ready)         outcome = WR_PUSH;
    else if (cfg_stop_on_full) outcome = WR_STALL;
    else                       outcome = WR_DROP;
  end

  stress_seq #(.SEQ_W(SEQ_W), .OVF_W(OVF_W)) u_seq (
    .clk(clk), .rst(rst), .outcome(outcome), .seq(seq), .ovf(overflow_count)
  );

  stress_drain #(.DRAIN_W(DRAIN_W)) u_drain (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_empty(rd_empty),
    .almost_empty(fifo_almost_empty), .almost_full(fifo_almost_full),
    .drain(drain), .occ_low(occ_low), .occ_high(occ_high)
  );

  assign wr_valid = slot;
  assign wr_data  = {drain, seq};

  a_r4_seq_advances: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (wr_ready || !cfg_stop_on_full))
      |=> (wr_data[SEQ_W-1:0] == $past(wr_data[SEQ_W-1:0]) + 1'b1));

  a_r5_valid_held: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready && cfg_stop_on_full && cfg_enable && !cfg_throttle)
      |=> wr_valid || !cfg_enable);

endmodule

// File: tb/test_occ_tag_stress_gen.sv
module test_occ_tag_stress_gen;
  localparam int CLK_P = 10;
  localparam int DEPTH = 256;
  localparam int AE_LVL = DEPTH * 30 / 100;
  localparam int AF_LVL = DEPTH * 70 / 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 1'b0, cfg_throttle = 1'b0, cfg_stop_on_full = 1'b0;
  logic rd_on = 1'b0;
  logic wr_valid, wr_ready, occ_low, occ_high;
  logic [31:0] wr_data;
  logic [15:0] overflow_count;

  // behavioural FIFO
  logic [31:0] mem [DEPTH];
  logic [7:0]  wp, rp;
  int          f_cnt;
  logic        f_empty, f_ae, f_af;
  logic [31:0] f_rdata;
  assign wr_ready = (f_cnt != DEPTH);
  assign f_empty  = (f_cnt == 0);
  assign f_ae     = (f_cnt <= AE_LVL);
  assign f_af     = (f_cnt >= AF_LVL);
  assign f_rdata  = mem[rp];

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; f_cnt <= 0;
    end else begin
      if (wr_valid && wr_ready) begin mem[wp] <= wr_data; wp <= wp + 8'd1; end
      if (rd_on && !f_empty) rp <= rp + 8'd1;
      f_cnt <= f_cnt + int'(wr_valid && wr_ready) - int'(rd_on && !f_empty);
    end
  end

  occ_tag_stress_gen i_occ_tag_stress_gen (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_throttle(cfg_throttle),
    .cfg_stop_on_full(cfg_stop_on_full), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_en(rd_on), .rd_empty(f_empty),
    .fifo_almost_empty(f_ae), .fifo_almost_full(f_af),
    .occ_low(occ_low), .occ_high(occ_high), .overflow_count(overflow_count)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard model state
  logic [31:0] exp_q [$];
  logic [1:0]  phase_m = 0;
  logic [15:0] seq_m = 0, drain_m = 0, ovf_m = 0, last_s = 0, gap_sum = 0;
  logic        pae_m = 0, paf_m = 0, last_ok = 0;
  int          rd_total = 0;

  // monitor: compare outputs with the model, pop FIFO reads against the queue
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst) begin
        phase_m = 0; seq_m = 0; drain_m = 0; ovf_m = 0; pae_m = 0; paf_m = 0;
        last_ok = 0; exp_q.delete();
      end else begin
        logic slot_m;
        slot_m = cfg_enable && (!cfg_throttle || phase_m != 2'd3);
        chk(wr_valid == slot_m, "R2 valid", {31'd0, wr_valid}, {31'd0, slot_m});
        chk(wr_data[15:0] == seq_m, "R4 seq", {16'd0, wr_data[15:0]}, {16'd0, seq_m});
        chk(wr_data[31:16] == drain_m, "R3 drain field", {16'd0, wr_data[31:16]}, {16'd0, drain_m});
        chk(overflow_count == ovf_m, "R6 overflow", {16'd0, overflow_count}, {16'd0, ovf_m});
        chk(occ_low == pae_m && occ_high == paf_m, "R9 occupancy",
            {30'd0, occ_high, occ_low}, {30'd0, paf_m, pae_m});
        if (slot_m) begin
          if (wr_ready) begin
            exp_q.push_back({drain_m, seq_m});
            seq_m = seq_m + 16'd1;
          end else if (!cfg_stop_on_full) begin
            seq_m = seq_m + 16'd1;
            if (ovf_m != 16'hFFFF) ovf_m = ovf_m + 16'd1;
          end
        end
        if (rd_on && !f_empty) begin
          if (exp_q.size() == 0) chk(1'b0, "R3 order (queue empty)", f_rdata, 32'd0);
          else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(f_rdata == e, "R3 order", f_rdata, e);
          end
          if (last_ok) gap_sum = gap_sum + (f_rdata[15:0] - last_s - 16'd1);
          last_s = f_rdata[15:0]; last_ok = 1;
          rd_total++;
          drain_m = drain_m + 16'd1;
        end
        if (cfg_enable) phase_m = phase_m + 2'd1;
        pae_m = f_ae; paf_m = f_af;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic at_sample;
    #(CLK_P/4 + 1);
  endtask

  initial begin
    logic [15:0] held;
    cyc(3);
    rst = 1'b0;
    at_sample();
    // R1: reset state
    chk(wr_data == 32'd0, "R1 data after reset", wr_data, 32'd0);
    chk(overflow_count == 16'd0, "R1 overflow after reset", {16'd0, overflow_count}, 32'd0);
    chk(!occ_low && !occ_high, "R1 status after reset", {30'd0, occ_high, occ_low}, 32'd0);
    chk(!wr_valid, "R2 disabled", {31'd0, wr_valid}, 32'd0);

    // full rate, stop mode, reader always on: drain wraps (R8)
    @(negedge clk); cfg_enable = 1; cfg_stop_on_full = 1; rd_on = 1;
    cyc(66000);
    rd_on = 0;
    cyc(1); at_sample();
    chk(rd_total > 65536, "R8 enough reads", rd_total, 32'd65537);
    chk(wr_data[31:16] == rd_total[15:0], "R8 drain wrap", {16'd0, wr_data[31:16]}, {16'd0, rd_total[15:0]});
    chk(overflow_count == 0, "R5 no loss at full rate", {16'd0, overflow_count}, 32'd0);

    // throttled: 30 slots in 40 cycles (R2)
    begin
      int nv;
      nv = 0;
      @(negedge clk); cfg_throttle = 1; rd_on = 1;
      for (int i = 0; i < 40; i++) begin
        at_sample();
        if (wr_valid) nv++;
        @(negedge clk);
      end
      chk(nv == 30, "R2 duty 3 of 4", nv, 32'd30);
    end

    // stop on full (R5, R9)
    cfg_throttle = 0; rd_on = 0;
    cyc(300); at_sample();
    chk(wr_valid && !wr_ready, "R5 stalled on full", {30'd0, wr_valid, wr_ready}, 32'd2);
    chk(occ_high, "R9 almost full reported", {31'd0, occ_high}, 32'd1);
    held = wr_data[15:0];
    cyc(5); at_sample();
    chk(wr_data[15:0] == held, "R5 sequence held", {16'd0, wr_data[15:0]}, {16'd0, held});
    chk(overflow_count == 0, "R5 no count while stalled", {16'd0, overflow_count}, 32'd0);
    @(negedge clk); rd_on = 1;
    cyc(400);
    cfg_enable = 0;
    cyc(300); at_sample();
    chk(occ_low && !occ_high, "R9 almost empty reported", {30'd0, occ_high, occ_low}, 32'd1);
    chk(gap_sum == 0, "R4 no gaps in stop mode", {16'd0, gap_sum}, 32'd0);

    // drop mode (R6)
    @(negedge clk); cfg_enable = 1; cfg_stop_on_full = 0; rd_on = 0;
    cyc(300);
    rd_on = 1;
    cyc(200);
    cfg_enable = 0;
    cyc(300); at_sample();
    chk(overflow_count > 16'd40, "R6 drops counted", {16'd0, overflow_count}, 32'd41);
    chk(gap_sum == overflow_count, "R6 gaps equal drops", {16'd0, gap_sum}, {16'd0, overflow_count});

    // reset mid-run restarts duty at first slot (R1, R2)
    @(negedge clk); rst = 1; cfg_enable = 1; cfg_throttle = 1; rd_on = 0;
    cyc(2);
    rst = 0;
    at_sample();
    chk(overflow_count == 0 && wr_data == 0, "R1 counters cleared", {16'd0, overflow_count} | wr_data, 32'd0);
    for (int i = 0; i < 4; i++) begin
      chk(wr_valid == (i != 3), "R1 duty restarts at first slot", {31'd0, wr_valid}, {31'd0, 1'(i != 3)});
      @(negedge clk); at_sample();
    end

    // overflow saturation (R7)
    @(negedge clk); cfg_throttle = 0; cfg_stop_on_full = 0;
    cyc(65900); at_sample();
    chk(overflow_count == 16'hFFFF, "R7 saturation", {16'd0, overflow_count}, 32'h0000FFFF);
    cyc(3); at_sample();
    chk(overflow_count == 16'hFFFF, "R7 stays saturated", {16'd0, overflow_count}, 32'h0000FFFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule